// File: doc/BRIEF.md
# Reset Cause Capture and Internal Reset Merger

This block gathers five internal reset requests and turns them into one synchronous internal reset. The five are an illegal-opcode trap, a watchdog expiry, a RAM parity error, an illegal memory access and a low-voltage detector. For each request it sets a sticky cause flag. The internal reset it produces is stretched to a fixed length after the most recent request. The surrounding chip drives the rest of the system's reset from this output. After restart, software reads the cause byte once to learn why the chip restarted, and that read leaves the byte clean for the next event.

The flags live in a single read-only byte on a simple bus port and are accessed only as a whole byte. The internal reset that the flags record does not clear them. A read clears them, and so do the two chip-level resets: the external reset pin and power-on reset. Both chip-level resets are asynchronous inputs. Each takes effect at once and is released through a two-flop synchronizer. The trap source is decoded from the opcode fetch stream, and it is masked while a debug-emulation input is high.

Top module: `rst_cause_capture`

## Requirements
- R1: The cause byte places the trap flag at bit 7, the watchdog flag at bit 4, the RAM parity flag at bit 2, the illegal-access flag at bit 1 and the low-voltage flag at bit 0. Bits 6, 5 and 3 always read 0, so all five causes at once read 0x97.
- R2: A request sampled high on a rising edge sets its flag, and the new value is visible from that edge on. A flag then stays set until one of the clears in R3, R4 or R5 takes place.
- R3: While the external reset pin is low, all flags are held clear, and the byte reads 0x00 once the reset has been released.
- R4: While power-on reset is low, all flags are held clear and the internal reset is idle. The first read after power-on reads 0x00.
- R5: A read of the cause byte (bus_en=1, bus_we=0, bus_addr=REG_ADDR) returns the value held before the read, and the flags are clear after that edge.
- R6: When a source request and a clearing read fall on the same edge, the flag of the new request is set after that edge, while the other flags clear.
- R7: A trap fires only when op_valid is high and opcode equals 0xFF. Any other opcode, or 0xFF without op_valid, sets nothing and starts no reset.
- R8: While dbg_emul is high, a 0xFF fetch sets no flag and leaves int_rst_n high.
- R9: int_rst_n (active low) goes low on the edge that samples a request and stays low for exactly 16 cycles after the last request. A new request restarts the count.
- R10: The internal reset does not clear the flags. A request that arrives while the internal reset is active ORs its flag into the byte.
- R11: Writes to the cause byte, and reads at any other address, leave the flags unchanged. A read at another address returns 0x00.
- R12: After both asynchronous resets are high, the block stays in reset for two more rising edges. Requests sampled on those edges are lost, and the third edge captures normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| dbg_emul | input | 1 | Debug emulation active; masks the trap source |
| op_valid | input | 1 | Opcode fetch strobe |
| opcode | input | 8 | Fetched opcode |
| wdt_req | input | 1 | Watchdog expiry request |
| parity_req | input | 1 | RAM parity error request |
| acc_req | input | 1 | Illegal memory access request |
| lvd_req | input | 1 | Low-voltage detector request |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write enable (writes have no effect) |
| bus_addr | input | 4 | Bus address |
| bus_wdata | input | 8 | Bus write data (ignored) |
| bus_rdata | output | 8 | Cause byte read data |
| int_rst_n | output | 1 | Stretched internal reset, active low |

## Verification
The bench aims at the edge where a request and a clearing read coincide. A design that lets the clear win would lose a cause that arrived exactly as software looked. It also checks that a second cause arriving mid-stretch is ORed in and restarts the stretch, so a design that reloads the byte or clears it on internal reset fails there. The bench counts the stretch length and checks that a 0xFF fetch under debug neither flags nor resets, which catches counter off-by-ones and a missing mask. Finally, it places requests on the two edges right after the asynchronous release, so a synchronizer one flop short or long is exposed by which of those requests survive.

// File: rtl/rcc_pkg.sv
// Package: shared constants and the flag-to-byte mapping for the reset
// cause capture block. Assumes five sources, indexed as below.
package rcc_pkg;

    localparam int NSRC     = 5;
    localparam int BYTE_W   = 8;

    // Source indices inside the internal flag vector
    localparam int IDX_LVD  = 0;
    localparam int IDX_ACC  = 1;
    localparam int IDX_PAR  = 2;
    localparam int IDX_WDT  = 3;
    localparam int IDX_TRAP = 4;

    // Bit positions inside the software-visible byte
    localparam int POS_LVD  = 0;
    localparam int POS_ACC  = 1;
    localparam int POS_PAR  = 2;
    localparam int POS_WDT  = 4;
    localparam int POS_TRAP = 7;

    typedef logic [NSRC-1:0] src_vec_t;

    // Spread the packed flags over the byte layout; unused bits stay 0
    function automatic logic [BYTE_W-1:0] pack_cause(input src_vec_t f);
        logic [BYTE_W-1:0] b;
        b           = '0;
        b[POS_LVD]  = f[IDX_LVD];
        b[POS_ACC]  = f[IDX_ACC];
        b[POS_PAR]  = f[IDX_PAR];
        b[POS_WDT]  = f[IDX_WDT];
        b[POS_TRAP] = f[IDX_TRAP];
        return b;
    endfunction

endpackage

// File: rtl/rcc_rst_sync.sv
// Module: two-flop reset synchronizer.
// Asserts asynchronously when arst_n falls and releases synchronously
// after DEPTH rising edges. Assumes arst_n may change at any time.
module rcc_rst_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [DEPTH-1:0] chain;

    // Shift ones in after release; clear the whole chain at once on assert
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], 1'b1};
        end
    end

    assign srst_n = chain[DEPTH-1];

endmodule

// File: rtl/rcc_src_detect.sv
// Module: source request decode.
// Builds the request vector from the four pulse inputs and the opcode
// fetch stream. The trap is raised for a valid fetch of TRAP_OPC, and it
// is suppressed while debug emulation is active. Purely combinational.
module rcc_src_detect
    import rcc_pkg::*;
#(
    parameter int              OPC_W    = 8,
    parameter logic [OPC_W-1:0] TRAP_OPC = '1
) (
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic             dbg_emul,
    input  logic             wdt_req,
    input  logic             parity_req,
    input  logic             acc_req,
    input  logic             lvd_req,
    output src_vec_t         req
);

    logic trap_hit;

    // Decode the illegal opcode and apply the debug mask
    always_comb begin
        trap_hit = op_valid && (opcode == TRAP_OPC) && !dbg_emul;
    end

    // Assemble the request vector in flag index order
    always_comb begin
        req           = '0;
        req[IDX_LVD]  = lvd_req;
        req[IDX_ACC]  = acc_req;
        req[IDX_PAR]  = parity_req;
        req[IDX_WDT]  = wdt_req;
        req[IDX_TRAP] = trap_hit;
    end

endmodule

// File: rtl/rcc_flag_reg.sv
// Module: sticky cause flags.
// Each flag sets on its request and stays until a read clear or the
// synchronous chip reset. A set on the same edge as a read clear wins.
// Assumes rst_n is already synchronous to clk.
module rcc_flag_reg
    import rcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_vec,
    input  logic     rd_clr,
    output src_vec_t flags
);

    // Clear-then-set update so new requests survive a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (rd_clr ? '0 : flags) | set_vec;
        end
    end

    // R2: a sampled request is visible in its flag after the edge
    p_set_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R2: without a read clear no flag falls
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((flags & $past(flags)) == $past(flags)));

    // R6: after a clearing read only the same-edge requests remain
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (flags == $past(set_vec)));

endmodule

// File: rtl/rcc_stretch.sv
// Module: internal reset stretcher.
// Any request loads the counter with LEN; the output stays active until
// the counter runs out, LEN cycles after the last request. Assumes rst_n
// is synchronous to clk.
module rcc_stretch #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);

    localparam int CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt;

    // Reload on a request, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (trig) begin
            cnt <= CNT_W'(LEN);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Registered active flag, low once the final counted cycle passes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else begin
            active <= trig || (cnt > CNT_W'(1));
        end
    end

    // R9: a request starts the stretch with a full count
    p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (active && cnt == CNT_W'(LEN)));

    // R9: the last counted cycle releases the reset
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && cnt == CNT_W'(1)) |=> !active);

    // R9: an idle stretcher stays idle without a request
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && cnt == '0) |=> !active);

endmodule

// File: rtl/rst_cause_capture.sv
// Module: reset cause capture top.
// Synchronizes the two chip resets, decodes the five internal reset
// sources, keeps the sticky cause byte on a read-to-clear bus port and
// drives the stretched internal reset. Assumes single-cycle bus reads
// with combinational read data.
module rst_cause_capture
    import rcc_pkg::*;
#(
    parameter int              ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 4'hA,
    parameter int              STRETCH_LEN = 16,
    parameter int              SYNC_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              dbg_emul,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic              wdt_req,
    input  logic              parity_req,
    input  logic              acc_req,
    input  logic              lvd_req,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              int_rst_n
);

    logic     chip_arst_n;
    logic     sys_rst_n;
    src_vec_t req;
    src_vec_t flags;
    logic     rd_hit;
    logic     stretch_on;
    logic     unused_wdata;

    // Either asynchronous reset resets the block
    assign chip_arst_n  = por_n & ext_rst_n;
    assign unused_wdata = ^bus_wdata;

    rcc_rst_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .arst_n (chip_arst_n),
        .srst_n (sys_rst_n)
    );

    rcc_src_detect #(.OPC_W(8), .TRAP_OPC(8'hFF)) u_detect (
        .op_valid   (op_valid),
        .opcode     (opcode),
        .dbg_emul   (dbg_emul),
        .wdt_req    (wdt_req),
        .parity_req (parity_req),
        .acc_req    (acc_req),
        .lvd_req    (lvd_req),
        .req        (req)
    );

    // Decode a read of the cause byte
    always_comb begin
        rd_hit = bus_en && !bus_we && (bus_addr == REG_ADDR);
    end

    rcc_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .set_vec (req),
        .rd_clr  (rd_hit),
        .flags   (flags)
    );

    rcc_stretch #(.LEN(STRETCH_LEN)) u_stretch (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .trig   (|req),
        .active (stretch_on)
    );

    // Return the pre-clear byte on a hit, zero elsewhere
    always_comb begin
        bus_rdata = rd_hit ? pack_cause(flags) : 8'h00;
    end

    assign int_rst_n = !stretch_on;

    // R11: writes and foreign addresses leave the flags alone
    p_no_write_effect_r11: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (!rd_hit && !(|req)) |=> (flags == $past(flags)));

    // R8: the trap flag does not rise while debug emulation is on
    p_dbg_mask_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (dbg_emul && !rd_hit) |=> (flags[IDX_TRAP] == $past(flags[IDX_TRAP])));

    // R10: the internal reset never drops a flag by itself
    p_int_keeps_flags_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (stretch_on && !rd_hit) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: tb/sim_rst_cause_capture.sv
module sim_rst_cause_capture;

    localparam logic [3:0] REG = 4'hA;

    logic       clk = 1'b0;
    logic       por_n, ext_rst_n, dbg_emul, op_valid;
    logic [7:0] opcode;
    logic       wdt_req, parity_req, acc_req, lvd_req;
    logic       bus_en, bus_we;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       int_rst_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rst_cause_capture u0 (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .dbg_emul(dbg_emul),
        .op_valid(op_valid), .opcode(opcode), .wdt_req(wdt_req),
        .parity_req(parity_req), .acc_req(acc_req), .lvd_req(lvd_req),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_rst_n(int_rst_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive the given sources for one edge; returns at the following negedge
    task automatic pulse(input logic w, input logic p, input logic a,
                         input logic l, input logic ov, input logic [7:0] opc);
        @(negedge clk);
        wdt_req = w; parity_req = p; acc_req = a; lvd_req = l;
        op_valid = ov; opcode = opc;
        @(negedge clk);
        wdt_req = 0; parity_req = 0; acc_req = 0; lvd_req = 0;
        op_valid = 0; opcode = 8'h00;
    endtask

    // Clearing read: checks the returned byte, flags clear on the edge
    task automatic rd(input string req, input logic [7:0] exp);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = REG;
        #2 chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && !int_rst_n; i++) @(negedge clk);
    endtask

    // Count negedges with int_rst_n low, starting at the current one
    task automatic count_low(output int n);
        n = 0;
        while (!int_rst_n && n < 60) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        // R4: after power-on release the byte is clean and no reset runs
        chk("R4 int_rst_n idle", int_rst_n, 1);
        rd("R4 por clears", 8'h00);
    endtask

    task automatic t_layout_and_sticky();
        pulse(1, 1, 1, 1, 1, 8'hFF);
        repeat (3) @(negedge clk);
        // R1: all five causes map to 0x97
        rd("R1 all causes", 8'h97);
        // R5: the previous read cleared the byte
        rd("R5 cleared after read", 8'h00);
        wait_idle();
        pulse(1, 0, 0, 0, 0, 8'h00);
        repeat (25) @(negedge clk);
        // R2: flag still set long after the request
        rd("R2 sticky watchdog", 8'h10);
    endtask

    task automatic t_trap_decode();
        int n;
        wait_idle();
        pulse(0, 0, 0, 0, 1, 8'hFE);
        chk("R7 opcode FE no reset", int_rst_n, 1);
        pulse(0, 0, 0, 0, 0, 8'hFF);
        chk("R7 FF without valid no reset", int_rst_n, 1);
        rd("R7 no trap flag", 8'h00);
        pulse(0, 0, 0, 0, 1, 8'hFF);
        chk("R7 trap starts reset", int_rst_n, 0);
        count_low(n);
        chk("R9 stretch length", n, 16);
        rd("R7 trap flag", 8'h80);
    endtask

    task automatic t_debug_mask();
        wait_idle();
        dbg_emul = 1;
        pulse(0, 0, 0, 0, 1, 8'hFF);
        chk("R8 no reset under debug", int_rst_n, 1);
        dbg_emul = 0;
        rd("R8 no flag under debug", 8'h00);
    endtask

    task automatic t_restart_and_or();
        int n;
        wait_idle();
        pulse(0, 1, 0, 0, 0, 8'h00);
        repeat (9) @(negedge clk);
        chk("R9 still active mid stretch", int_rst_n, 0);
        pulse(0, 0, 1, 0, 0, 8'h00);
        count_low(n);
        chk("R9 restart after last request", n, 16);
        // R10: both flags kept through and after the internal reset
        rd("R10 OR during internal reset", 8'h06);
    endtask

    task automatic t_read_collision();
        pulse(1, 0, 0, 0, 0, 8'h00);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = REG; lvd_req = 1;
        #2 chk("R5 pre-clear value", bus_rdata, 8'h10);
        @(negedge clk);
        bus_en = 0; lvd_req = 0;
        rd("R6 new flag survives read", 8'h01);
    endtask

    task automatic t_ignored_access();
        pulse(0, 0, 0, 1, 0, 8'h00);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = REG; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 0; bus_addr = 4'h3;
        #2 chk("R11 other address reads 0", bus_rdata, 8'h00);
        @(negedge clk);
        bus_en = 0;
        rd("R11 flags unchanged", 8'h01);
    endtask

    task automatic t_ext_pin_and_sync();
        pulse(1, 0, 0, 0, 0, 8'h00);
        @(negedge clk);
        #3 ext_rst_n = 0;
        repeat (3) @(negedge clk);
        ext_rst_n = 1;
        wdt_req = 1;
        @(negedge clk);
        wdt_req = 0; acc_req = 1;
        @(negedge clk);
        acc_req = 0; lvd_req = 1;
        @(negedge clk);
        lvd_req = 0;
        // R3 cleared the old watchdog flag; R12 drops the first two pulses
        rd("R3 R12 pin clear and sync", 8'h01);
        wait_idle();
        #3 ext_rst_n = 0;
        @(negedge clk);
        ext_rst_n = 1;
        repeat (3) @(negedge clk);
        rd("R3 reads 0 after pin reset", 8'h00);
    endtask

    task automatic t_por_again();
        pulse(0, 1, 0, 0, 0, 8'h00);
        #3 por_n = 0;
        repeat (2) @(negedge clk);
        chk("R4 internal reset idle during por", int_rst_n, 1);
        por_n = 1;
        repeat (3) @(negedge clk);
        rd("R4 por wipes flags", 8'h00);
    endtask

    initial begin
        por_n = 0; ext_rst_n = 1; dbg_emul = 0; op_valid = 0; opcode = 0;
        wdt_req = 0; parity_req = 0; acc_req = 0; lvd_req = 0;
        bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        por_n = 1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_layout_and_sticky();
        t_trap_decode();
        t_debug_mask();
        t_restart_and_or();
        t_read_collision();
        t_ignored_access();
        t_ext_pin_and_sync();
        t_por_again();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule